// File: doc/BRIEF.md
# Set/Clear Register Bank with Edge-Latched Interrupts

This block is a small control and status bank reached over a byte-wide read/write bus with an 8-bit address. Every writable register appears at two neighbouring addresses. A write to the even address ORs ones into the register. A write to the odd address removes the bits given as ones. Software can therefore change single bits without a read-modify-write sequence. A read at either address returns the current value. Fixed identification bytes and a live view of the status inputs are also readable.

Asynchronous status inputs pass through a synchronizer and are then edge-detected. Two independent masks choose, per bit, whether a rising or a falling transition is captured. Captured edges set bits in an interrupt latch, and a single active-high interrupt output reports whether any latch bit is set. Software acknowledges a latch bit by writing a one to the latch's clear address.

Top module: `irq_csr_bank`

## Requirements
- R1: A write to a set address (04h, 06h, 12h, 0Ah, 0Ch, 0Eh) sets every register bit written as 1 and leaves bits written as 0 unchanged, visible on the next clock.
- R2: A write to a clear address (05h, 07h, 13h, 0Bh, 0Dh, 0Fh) clears every register bit written as 1 and leaves bits written as 0 unchanged.
- R3: A read at either the set address or the clear address of a register returns that register's current value, combinationally on rdata_o.
- R4: Register map: control A at 04h/05h, control B at 06h/07h, control C at 12h/13h, interrupt latch at 0Ah/0Bh, falling-edge enable at 0Ch/0Dh, rising-edge enable at 0Eh/0Fh.
- R5: Identification reads return 83h at 00h, 04h at 01h, C4h at 02h and A0h at 03h.
- R6: Address 08h returns the synchronized status. A change on status_i appears there after the second rising clock edge.
- R7: A 0-to-1 transition of a status bit whose rising-edge enable bit is 1 sets the matching latch bit, visible after the third rising clock edge following the input change.
- R8: A 1-to-0 transition of a status bit whose falling-edge enable bit is 1 sets the matching latch bit with the same latency.
- R9: A transition whose direction is not enabled for that bit leaves the latch bit unchanged.
- R10: When a clear write to the latch and a newly captured edge on the same bit fall in the same cycle, the bit remains set.
- R11: irq_o is high exactly when at least one latch bit is 1.
- R12: Writes to 00h–03h, 08h and unmapped addresses change no register. Reads of unmapped addresses return 00h.
- R13: After reset, every control, latch and enable register reads 00h and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one write per cycle high |
| status_i | input | 8 | Asynchronous status inputs |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt, high while any latch bit is set |

## Verification
The hardest case to reach from the ports is a clear write to the latch that lands on the same clock edge as a freshly captured edge on the same bit. The edge arrives three clocks after the input changes, so the write has to be timed to that latency. A directed case changes a status bit and then issues the clear strobe exactly two falling clock edges later. A long seeded random run then mixes bit toggles with writes to all addresses, so that other coincidences between writes and edges occur on their own. Those runs are checked against a cycle model of the bank that the bench builds from the requirements.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 8;
  localparam int unsigned NREG = 6;

  localparam int unsigned IDX_CTRL_A = 0;
  localparam int unsigned IDX_CTRL_B = 1;
  localparam int unsigned IDX_CTRL_C = 2;
  localparam int unsigned IDX_LATCH  = 3;
  localparam int unsigned IDX_FALL   = 4;
  localparam int unsigned IDX_RISE   = 5;

  // set address of each register; clear address is set address | 1
  localparam logic [AW-1:0] SET_ADDR [NREG] = '{8'h04, 8'h06, 8'h12, 8'h0A, 8'h0C, 8'h0E};
  localparam logic [AW-1:0] ADDR_SRC = 8'h08;
  localparam logic [AW-1:0] ADDR_ID_LAST = 8'h03;
endpackage

// File: rtl/status_sync.sv
module status_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] event_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  assign rise    = src_i & ~prev_q;
  assign fall    = ~src_i & prev_q;
  assign event_o = (rise & rise_en_i) | (fall & fall_en_i);

  // no captured edge on a bit whose source held its value
  p_event_needs_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o & ~(src_i ^ prev_q)) == '0);
endmodule

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m, clr_m, q_d;

  assign set_m = set_we_i ? wdata_i : '0;
  assign clr_m = clr_we_i ? wdata_i : '0;
  // hardware set overrides a software clear in the same cycle
  assign q_d   = ((q_o | set_m) & ~clr_m) | hw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  p_set_ones_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> (q_o & $past(wdata_i)) == $past(wdata_i));

  p_clr_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (q_o & $past(wdata_i & ~hw_set_i)) == '0);

  p_hw_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> (q_o & $past(hw_set_i)) == $past(hw_set_i));
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [2*DW-1:0]    VENDOR_ID   = 16'h0483,
  parameter logic [2*DW-1:0]    PRODUCT_ID  = 16'hA0C4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NREG-1:0][DW-1:0] reg_q;
  logic [NREG-1:0]         set_we, clr_we, pair_hit;
  logic [DW-1:0]           src_sync, edge_ev;

  status_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(status_i), .q_o(src_sync)
  );

  edge_capture #(.W(DW)) u_edge (
    .clk_i, .rst_ni,
    .src_i    (src_sync),
    .rise_en_i(reg_q[IDX_RISE]),
    .fall_en_i(reg_q[IDX_FALL]),
    .event_o  (edge_ev)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign pair_hit[i] = (addr_i[AW-1:1] == SET_ADDR[i][AW-1:1]);
    assign set_we[i]   = wr_en_i && pair_hit[i] && !addr_i[0];
    assign clr_we[i]   = wr_en_i && pair_hit[i] &&  addr_i[0];

    setclr_reg #(.W(DW)) u_reg (
      .clk_i, .rst_ni,
      .set_we_i(set_we[i]),
      .clr_we_i(clr_we[i]),
      .wdata_i,
      .hw_set_i((i == IDX_LATCH) ? edge_ev : '0),
      .q_o     (reg_q[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i <= ADDR_ID_LAST) begin
      case (addr_i[1:0])
        2'd0:    rdata_o = VENDOR_ID[DW-1:0];
        2'd1:    rdata_o = VENDOR_ID[2*DW-1:DW];
        2'd2:    rdata_o = PRODUCT_ID[DW-1:0];
        default: rdata_o = PRODUCT_ID[2*DW-1:DW];
      endcase
    end else if (addr_i == ADDR_SRC) begin
      rdata_o = src_sync;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (pair_hit[i]) rdata_o = reg_q[i];
    end
  end

  assign irq_o = |reg_q[IDX_LATCH];

  p_stray_write_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pair_hit == '0) |=> $stable(reg_q[2:0]) && $stable(reg_q[5:4]));

  p_irq_drops_after_full_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we[IDX_LATCH] && (wdata_i | ~reg_q[IDX_LATCH]) == '1 && edge_ev == '0) |=> !irq_o);
endmodule

// File: tb/irq_csr_bank_test.sv
`timescale 1ns/1ps
module irq_csr_bank_test;
  logic       clk = 0;
  logic       rst_ni = 0;
  logic [7:0] addr = 0, wdata = 0, status = 0;
  logic       wr_en = 0;
  logic [7:0] rdata;
  logic       irq;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  irq_csr_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .status_i(status), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  localparam logic [7:0] SETA [6] = '{8'h04, 8'h06, 8'h12, 8'h0A, 8'h0C, 8'h0E};
  logic [7:0] m_reg [6];
  logic [7:0] m_s1, m_s2, m_prev;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 6; i++) m_reg[i] <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
    end else begin
      logic [7:0] nv [6];
      logic [7:0] ev;
      ev = (m_s2 & ~m_prev & m_reg[5]) | (~m_s2 & m_prev & m_reg[4]);
      for (int i = 0; i < 6; i++) begin
        nv[i] = m_reg[i];
        if (wr_en && addr == SETA[i])          nv[i] = nv[i] | wdata;
        if (wr_en && addr == (SETA[i] | 8'h1)) nv[i] = nv[i] & ~wdata;
      end
      nv[3] = nv[3] | ev;
      for (int i = 0; i < 6; i++) m_reg[i] <= nv[i];
      m_s1 <= status; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return 8'h83;
      8'h01: return 8'h04;
      8'h02: return 8'hC4;
      8'h03: return 8'hA0;
      8'h08: return m_s2;
      default: begin
        for (int i = 0; i < 6; i++)
          if (a == SETA[i] || a == (SETA[i] | 8'h1)) return m_reg[i];
        return 8'h00;
      end
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // call right after a falling edge
  task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_n(3);
    // R13 reset state
    rd(8'h04, 8'h00, "R13"); rd(8'h0B, 8'h00, "R13"); rd(8'h0E, 8'h00, "R13");
    chk("R13 irq", {7'd0, irq}, 8'h00);
    rst_ni = 1;
    wait_n(1);

    // R5 identification
    rd(8'h00, 8'h83, "R5"); rd(8'h01, 8'h04, "R5");
    rd(8'h02, 8'hC4, "R5"); rd(8'h03, 8'hA0, "R5");

    // R1 R2 R3 R4 set/clear semantics over the map
    wr(8'h04, 8'hA5); rd(8'h04, 8'hA5, "R1"); rd(8'h05, 8'hA5, "R3");
    wr(8'h04, 8'h0A); rd(8'h04, 8'hAF, "R1 zeros keep");
    wr(8'h05, 8'h81); rd(8'h04, 8'h2E, "R2");
    wr(8'h06, 8'h3C); rd(8'h07, 8'h3C, "R4 ctrl B");
    wr(8'h12, 8'hF0); wr(8'h13, 8'h30); rd(8'h12, 8'hC0, "R4 ctrl C");
    rd(8'h04, 8'h2E, "R4 ctrl A isolated");

    // R12 stray writes
    wr(8'h00, 8'hFF); wr(8'h08, 8'hFF); wr(8'h14, 8'hFF); wr(8'h09, 8'hFF);
    rd(8'h00, 8'h83, "R12 id"); rd(8'h12, 8'hC0, "R12 ctrl C");
    rd(8'h0C, 8'h00, "R12 mask"); rd(8'h09, 8'h00, "R12 unmapped");
    rd(8'hFF, 8'h00, "R12 unmapped");

    // R6 R7 R11 rising edge capture latency
    wr(8'h0E, 8'h01);
    status[0] = 1'b1;
    wait_n(1); rd(8'h08, 8'h00, "R6 early");
    wait_n(1); rd(8'h08, 8'h01, "R6"); rd(8'h0A, 8'h00, "R7 early");
    wait_n(1); rd(8'h0A, 8'h01, "R7"); chk("R11 irq high", {7'd0, irq}, 8'h01);
    wr(8'h0B, 8'h01); rd(8'h0A, 8'h00, "R2 latch");
    chk("R11 irq low", {7'd0, irq}, 8'h00);

    // R9 disabled directions
    status[0] = 1'b0; wait_n(4); rd(8'h0A, 8'h00, "R9 fall off");
    wr(8'h0C, 8'h02);
    status[1] = 1'b1; wait_n(4); rd(8'h0A, 8'h00, "R9 rise off");
    // R8 falling edge
    status[1] = 1'b0; wait_n(3); rd(8'h0A, 8'h02, "R8");

    // R10 clear and new edge in the same cycle
    wr(8'h0E, 8'h02); wr(8'h0A, 8'h04); rd(8'h0A, 8'h06, "R1 latch set");
    status[1] = 1'b1;
    wait_n(2);
    addr = 8'h0B; wdata = 8'h06; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(8'h0A, 8'h02, "R10");

    // seeded random run against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) status = status ^ (8'h1 << ($urandom % 8));
      wr_en = ($urandom % 3 == 0);
      wdata = 8'($urandom);
      if ($urandom % 4 != 0) addr = 8'($urandom % 20);
      else                   addr = 8'($urandom);
      #1;
      chk("R3 random read", rdata, exp_read(addr));
      chk("R11 random irq", {7'd0, irq}, {7'd0, |m_reg[3]});
    end
    @(negedge clk); wr_en = 0;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule